// File: doc/BRIEF.md
# Accumulator and Digit Rotate Unit

This unit carries out the rotate operations of an 8-bit processor core. Four of them act on the accumulator alone and move it by one bit position, either as a closed ring or through the carry flag. Two more shift 4-bit digits in a ring made of the accumulator's low nibble and the two nibbles of a memory byte. The unit reads that byte through a simple request/ready port, permutes the three nibbles and writes the byte back.

The core presents an opcode, the current accumulator, the carry and a byte address, and pulses `start`. The unit captures these operands on that edge. The new accumulator and carry appear on `acc_out` and `cy_out`, and `done` pulses high for one cycle in the same cycle. Both outputs keep their value until the next operation completes. The controller has five states. ST_IDLE waits for `start`. ST_BIT completes a register-only operation in one step. ST_RD holds the memory read. ST_PAD fills the cycle budget of a digit rotate. ST_WR holds the write-back. The transitions are ST_IDLE to ST_BIT (start with a register-only code), ST_IDLE to ST_RD (start with a digit code), ST_BIT to ST_IDLE (always), ST_RD to ST_PAD (ready), ST_PAD to ST_WR (pad count reached) and ST_WR to ST_IDLE (ready). Every state other than those transitions holds itself.

Top module: `acc_rotate_unit`

## Requirements
- R1: Opcode 0 rotates the accumulator right one bit. Bit i takes old bit i+1, and old bit 0 goes to both bit 7 and the carry.
- R2: Opcode 1 rotates the accumulator left one bit. Bit i takes old bit i-1, and old bit 7 goes to both bit 0 and the carry.
- R3: Opcode 2 rotates right through the carry. The carry takes old bit 0, bit 7 takes the old carry, and the other bits move down one position.
- R4: Opcode 3 rotates left through the carry. The carry takes old bit 7, bit 0 takes the old carry, and the other bits move up one position.
- R5: Opcode 4 (digit right) reads the byte at `ptr_in` and writes it back to the same address. The accumulator low nibble becomes the byte's old low nibble, the byte's high nibble becomes the old accumulator low nibble, and the byte's low nibble becomes its old high nibble.
- R6: Opcode 5 (digit left) reads and writes back the same way. The accumulator low nibble becomes the byte's old high nibble, the byte's low nibble becomes the old accumulator low nibble, and the byte's high nibble becomes its old low nibble.
- R7: Both digit rotates leave the accumulator high nibble and the carry unchanged.
- R8: Counted from the `start` edge as edge 1, `done` is set by edge 2 for opcodes 0–3, 6 and 7. It is set by edge 10 for a digit rotate that meets no wait states.
- R9: Each cycle that `mem_ready` is low during the read or the write-back adds one cycle to a digit rotate. While a request waits, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady, and `mem_we` is high only during the write-back.
- R10: Opcodes 6 and 7 return the accumulator and carry unchanged, and make no memory request.
- R11: A `start` pulse that arrives while an operation is in progress is ignored.
- R12: After reset, `acc_out`, `cy_out`, `done`, `mem_req` and `mem_we` are all 0, and `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; operands are captured on this edge |
| op | input | 3 | Operation code (0–7) |
| acc_in | input | 8 | Accumulator before the operation |
| cy_in | input | 1 | Carry before the operation |
| ptr_in | input | ADDR_W | Address of the memory byte used by the digit rotates |
| acc_out | output | 8 | Accumulator after the last completed operation |
| cy_out | output | 1 | Carry after the last completed operation |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled on the edge where ready is high |
| mem_ready | input | 1 | Completes the current request |

## Verification
A corrupted state register or pad counter shows up at once as a `done` pulse in the wrong cycle, so the bench counts edges from `start` to `done` for every operation and for every wait pattern. A wrong captured read byte or misrouted nibble appears at the write-back handshake, one cycle before `done`, as a bad `mem_wdata`. It also appears in `acc_out` at `done`. A state that entered the wrong branch makes a stray memory request during a register-only operation, or a stray bit rotate after a mid-operation start, and the bench catches it within that operation.

// File: rtl/rotu_pkg.sv
package rotu_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = 4;

    typedef enum logic [2:0] {
        OP_ROR  = 3'd0,
        OP_ROL  = 3'd1,
        OP_RORC = 3'd2,
        OP_ROLC = 3'd3,
        OP_DIGR = 3'd4,
        OP_DIGL = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } rot_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BIT  = 3'd1,
        ST_RD   = 3'd2,
        ST_PAD  = 3'd3,
        ST_WR   = 3'd4
    } seq_state_e;

    function automatic logic op_is_digit(input rot_op_e o);
        return (o == OP_DIGR) || (o == OP_DIGL);
    endfunction

endpackage

// File: rtl/rotu_bit_alu.sv
module rotu_bit_alu
    import rotu_pkg::*;
(
    input  rot_op_e            op,
    input  logic [BYTE_W-1:0]  a_in,
    input  logic               c_in,
    output logic [BYTE_W-1:0]  a_out,
    output logic               c_out
);

    logic [BYTE_W-1:0] shr;
    logic [BYTE_W-1:0] shl;

    // Inner positions of both shifts.
    genvar gi;
    generate
        for (gi = 0; gi < BYTE_W - 1; gi++) begin : g_inner
            assign shr[gi]   = a_in[gi+1];
            assign shl[gi+1] = a_in[gi];
        end
    endgenerate

    // The filled end bit depends on ring or through-carry.
    always_comb begin
        shr[BYTE_W-1] = (op == OP_RORC) ? c_in : a_in[0];
        shl[0]        = (op == OP_ROLC) ? c_in : a_in[BYTE_W-1];
    end

    always_comb begin
        a_out = a_in;
        c_out = c_in;
        unique case (op)
            OP_ROR, OP_RORC: begin
                a_out = shr;
                c_out = a_in[0];
            end
            OP_ROL, OP_ROLC: begin
                a_out = shl;
                c_out = a_in[BYTE_W-1];
            end
            default: begin
                a_out = a_in;
                c_out = c_in;
            end
        endcase
    end

endmodule

// File: rtl/rotu_digit_alu.sv
module rotu_digit_alu
    import rotu_pkg::*;
(
    input  logic               left,
    input  logic [BYTE_W-1:0]  a_in,
    input  logic [BYTE_W-1:0]  m_in,
    output logic [BYTE_W-1:0]  a_out,
    output logic [BYTE_W-1:0]  m_out
);

    logic [NIB_W-1:0] a_lo, m_lo, m_hi;

    assign a_lo = a_in[NIB_W-1:0];
    assign m_lo = m_in[NIB_W-1:0];
    assign m_hi = m_in[BYTE_W-1:NIB_W];

    always_comb begin
        if (left) begin
            a_out = {a_in[BYTE_W-1:NIB_W], m_hi};
            m_out = {m_lo, a_lo};
        end else begin
            a_out = {a_in[BYTE_W-1:NIB_W], m_lo};
            m_out = {a_lo, m_hi};
        end
    end

endmodule

// File: rtl/rotu_seq.sv
module rotu_seq
    import rotu_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned DIGIT_CLOCKS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op_in,
    input  logic [BYTE_W-1:0]  acc_in,
    input  logic               cy_in,
    input  logic [ADDR_W-1:0]  ptr_in,
    input  logic [BYTE_W-1:0]  mem_rdata,
    input  logic               mem_ready,
    input  logic [BYTE_W-1:0]  bit_acc,
    input  logic               bit_cy,
    input  logic [BYTE_W-1:0]  dig_acc,
    input  logic [BYTE_W-1:0]  dig_mem,
    output rot_op_e            op_q,
    output logic [BYTE_W-1:0]  acc_q,
    output logic               cy_q,
    output logic [BYTE_W-1:0]  mem_q,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BYTE_W-1:0]  mem_wdata,
    output logic               done,
    output logic [BYTE_W-1:0]  acc_out,
    output logic               cy_out
);

    // Two cycles go to start and read, one to the write; the rest is padding.
    localparam int unsigned PAD_N = (DIGIT_CLOCKS > 3) ? DIGIT_CLOCKS - 3 : 1;
    localparam int unsigned CNT_W = (PAD_N > 1) ? $clog2(PAD_N) : 1;
    localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(PAD_N - 1);

    seq_state_e        state, state_nx;
    logic [CNT_W-1:0]  pad_cnt;
    logic              rd_hs, wr_hs;

    assign rd_hs = (state == ST_RD) && mem_ready;
    assign wr_hs = (state == ST_WR) && mem_ready;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = op_is_digit(rot_op_e'(op_in)) ? ST_RD : ST_BIT;
            ST_BIT:  state_nx = ST_IDLE;
            ST_RD:   if (mem_ready) state_nx = ST_PAD;
            ST_PAD:  if (pad_cnt == PAD_LAST) state_nx = ST_WR;
            ST_WR:   if (mem_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Operand capture, pad counter and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_ROR;
            acc_q    <= '0;
            cy_q     <= 1'b0;
            mem_q    <= '0;
            mem_addr <= '0;
            pad_cnt  <= '0;
            done     <= 1'b0;
            acc_out  <= '0;
            cy_out   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE && start) begin
                op_q     <= rot_op_e'(op_in);
                acc_q    <= acc_in;
                cy_q     <= cy_in;
                mem_addr <= ptr_in;
            end
            if (rd_hs) begin
                mem_q   <= mem_rdata;
                pad_cnt <= '0;
            end
            if (state == ST_PAD) pad_cnt <= pad_cnt + 1'b1;
            if (state == ST_BIT) begin
                acc_out <= bit_acc;
                cy_out  <= bit_cy;
                done    <= 1'b1;
            end
            if (wr_hs) begin
                acc_out <= dig_acc;
                cy_out  <= cy_q;
                done    <= 1'b1;
            end
        end
    end

    // Memory port outputs.
    always_comb begin
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_wdata = dig_mem;
    end

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

    a_r9_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hs |=> (done && cy_out == $past(cy_q)
                   && acc_out[BYTE_W-1:NIB_W] == $past(acc_q[BYTE_W-1:NIB_W])));

    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(op_q) && $stable(acc_q));

    a_r10_no_mem_bitop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT) |-> !mem_req);

endmodule

// File: rtl/acc_rotate_unit.sv
module acc_rotate_unit
    import rotu_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned DIGIT_CLOCKS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op,
    input  logic [7:0]         acc_in,
    input  logic               cy_in,
    input  logic [ADDR_W-1:0]  ptr_in,
    output logic [7:0]         acc_out,
    output logic               cy_out,
    output logic               done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ready
);

    rot_op_e            op_q;
    logic [BYTE_W-1:0]  acc_q, mem_q, bit_acc, dig_acc, dig_mem;
    logic               cy_q, bit_cy;

    rotu_seq #(
        .ADDR_W       (ADDR_W),
        .DIGIT_CLOCKS (DIGIT_CLOCKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_in     (op),
        .acc_in    (acc_in),
        .cy_in     (cy_in),
        .ptr_in    (ptr_in),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .bit_acc   (bit_acc),
        .bit_cy    (bit_cy),
        .dig_acc   (dig_acc),
        .dig_mem   (dig_mem),
        .op_q      (op_q),
        .acc_q     (acc_q),
        .cy_q      (cy_q),
        .mem_q     (mem_q),
        .mem_addr  (mem_addr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .done      (done),
        .acc_out   (acc_out),
        .cy_out    (cy_out)
    );

    rotu_bit_alu u_bit (
        .op    (op_q),
        .a_in  (acc_q),
        .c_in  (cy_q),
        .a_out (bit_acc),
        .c_out (bit_cy)
    );

    rotu_digit_alu u_dig (
        .left  (op_q == OP_DIGL),
        .a_in  (acc_q),
        .m_in  (mem_q),
        .a_out (dig_acc),
        .m_out (dig_mem)
    );

    // Digit rotates write back to the byte they read.
    a_r5_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (!mem_req || $stable(mem_addr)));

endmodule

// File: tb/sim_acc_rotate_unit.sv
`timescale 1ns/1ps
module sim_acc_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [7:0]  acc_in = 8'h00;
    logic        cy_in = 1'b0;
    logic [15:0] ptr_in = 16'h0000;
    logic [7:0]  acc_out, mem_wdata;
    logic        cy_out, done, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rd_w = 0, wr_w = 0, wcnt = 0;
    int req_cycles = 0;
    logic [7:0]  wr_seen;
    logic [15:0] rd_addr_seen, wr_addr_seen;
    bit finished = 0;

    always #2.5 clk = ~clk;

    acc_rotate_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_in(acc_in),
        .cy_in(cy_in), .ptr_in(ptr_in), .acc_out(acc_out), .cy_out(cy_out),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Memory responder: ready after the programmed number of wait cycles.
    always @(negedge clk) begin
        if (mem_req) begin
            req_cycles++;
            if (wcnt >= (mem_we ? wr_w : rd_w)) mem_ready = 1'b1;
            else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) begin
            wr_seen <= mem_wdata;
            wr_addr_seen <= mem_addr;
        end
        if (mem_req && mem_ready && !mem_we) rd_addr_seen <= mem_addr;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input logic [2:0] o, input logic [7:0] a, input logic c,
                                  input logic [7:0] m, output logic [7:0] ea,
                                  output logic ec, output logic [7:0] em);
        ea = a; ec = c; em = m;
        case (o)
            3'd0: begin ea = (a >> 1) | (a << 7); ec = a[0]; end
            3'd1: begin ea = (a << 1) | (a >> 7); ec = a[7]; end
            3'd2: begin ea = (a >> 1) | ({7'd0, c} << 7); ec = a[0]; end
            3'd3: begin ea = (a << 1) | {7'd0, c}; ec = a[7]; end
            3'd4: begin ea = (a & 8'hF0) | (m & 8'h0F); em = ((a & 8'h0F) << 4) | (m >> 4); end
            3'd5: begin ea = (a & 8'hF0) | (m >> 4); em = ((m & 8'h0F) << 4) | (a & 8'h0F); end
            default: ;
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic c,
                          input logic [7:0] m, input logic [15:0] p,
                          input int rw, input int ww, input bit glitch);
        logic [7:0] ea, em;
        logic ec;
        int n;
        bit dig;
        string tag;
        dig = (o == 3'd4) || (o == 3'd5);
        case (o)
            3'd0: tag = "R1";
            3'd1: tag = "R2";
            3'd2: tag = "R3";
            3'd3: tag = "R4";
            3'd4: tag = "R5";
            3'd5: tag = "R6";
            default: tag = "R10";
        endcase
        model(o, a, c, m, ea, ec, em);
        rd_w = rw; wr_w = ww; mem_rdata = m; req_cycles = 0;
        @(negedge clk);
        op = o; acc_in = a; cy_in = c; ptr_in = p; start = 1'b1;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            op = 3'd0; acc_in = ~a; cy_in = ~c;
            if (glitch && n == 3) start = 1'b1;  // R11: pulse while busy
            if (glitch && n == 4) start = 1'b0;
            if (done || n > 60) break;
        end
        chk({tag, " acc"}, acc_out, ea);
        chk({tag, " cy"}, cy_out, ec);
        if (dig) begin
            chk({tag, " wdata"}, wr_seen, em);
            chk({tag, " addr"}, {rd_addr_seen, wr_addr_seen}, {p, p});
            chk("R7 acc hi / cy", {acc_out[7:4], cy_out}, {a[7:4], c});
            chk("R8/R9 digit cycles", n, 10 + rw + ww);
        end else begin
            chk("R8 bit cycles", n, 2);
            chk("R10 no mem access", req_cycles, 0);
        end
        if (glitch) chk("R11 start ignored while busy", {acc_out, cy_out}, {ea, ec});
        @(negedge clk);
        chk("R12 done single pulse", done, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        chk("R12 reset acc/cy", {acc_out, cy_out}, 9'd0);
        chk("R12 reset ctl", {done, mem_req, mem_we}, 3'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Directed corner cases.
        run_op(3'd0, 8'h01, 1'b0, 8'h00, 16'h0, 0, 0, 0);
        run_op(3'd1, 8'h80, 1'b0, 8'h00, 16'h0, 0, 0, 0);
        run_op(3'd2, 8'h00, 1'b1, 8'h00, 16'h0, 0, 0, 0);
        run_op(3'd3, 8'hFF, 1'b0, 8'h00, 16'h0, 0, 0, 0);
        run_op(3'd4, 8'hA5, 1'b1, 8'h3C, 16'h1234, 0, 0, 0);
        run_op(3'd5, 8'hA5, 1'b0, 8'h3C, 16'hBEEF, 0, 0, 0);
        run_op(3'd4, 8'h7E, 1'b0, 8'h91, 16'h0042, 3, 0, 0);
        run_op(3'd5, 8'h19, 1'b1, 8'hE2, 16'hFFFF, 0, 4, 0);
        run_op(3'd6, 8'h5A, 1'b1, 8'h00, 16'h0, 0, 0, 0);
        run_op(3'd7, 8'hC3, 1'b0, 8'h00, 16'h0, 0, 0, 0);
        run_op(3'd4, 8'h12, 1'b1, 8'h34, 16'h0100, 1, 2, 1);
        run_op(3'd0, 8'h6D, 1'b1, 8'h00, 16'h0, 0, 0, 1);
        // Random stimulus.
        for (int i = 0; i < 80; i++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            run_op(o, 8'($urandom), 1'($urandom), 8'($urandom), 16'($urandom),
                   $urandom_range(0, 3), $urandom_range(0, 3), (i % 9) == 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule